// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the processor-side register file of a byte-wide DMA controller with four channels. A processor reaches it through an 8-bit data bus and a 5-bit register address. For each channel it keeps a 16-bit memory pointer, a 16-bit byte count and a control byte. Three registers are shared by all channels: a priority register whose bit 0 enables transfers globally, an interrupt register, and a data-chain register. The bus timing of the transfers is handled by a separate engine. That engine drives the start, completion and pointer/count update inputs of this block.

Some registers protect certain bits from writes. Others clear status bits when they are read. The interrupt register works as a sticky summary: its bit 7 is set whenever a channel with its enable bit set has its completion flag raised. A two-state machine drives the interrupt pin from that bit. The machine is in IRQ_QUIET after reset. It moves to IRQ_RAISED on the clock after the summary bit is seen set. It returns to IRQ_QUIET on the clock after the summary bit is seen clear. In every other case it stays in its current state.

Read data is combinational from the current address. A read strobe applies its clearing side effects at the clock edge that ends the read, so the value returned is the value before the clear.

Top module: `dmac_regfile`

## Requirements
- R1: Addresses 0x00 to 0x0F form four groups of four bytes, one group per channel, selected by address bits 3:2. Within a group, address bits 1:0 pick the byte: 0 is the pointer high byte, 1 the pointer low byte, 2 the count high byte and 3 the count low byte. Each byte can be written and read back.
- R2: The control register of channel n is at address 0x10+n. A write changes only bits 3:0. Bit 7 (completion) and bit 6 (busy) keep their values, and bits 5:4 read as 0.
- R3: Reading a control register returns its full value. At that clock edge bit 7 is cleared, unless a completion pulse for the same channel arrives in the same cycle.
- R4: The priority register at 0x14 stores a write masked with 0x8F. Output `xfer_enable` equals its bit 0.
- R5: A write to the interrupt register at 0x15 changes only bits 3:0, which are the enables for channels 0 to 3. It never changes bit 7.
- R6: A read of 0x15 returns ((data-chain register shifted right by 4) OR 0x80) AND the interrupt register. The same read clears data-chain bits 7:4 and clears interrupt bit 7, unless the set condition of R9 holds in that cycle.
- R7: The data-chain register at 0x16 takes writes only in bits 3:0. A read of 0x16 returns only bits 3:0.
- R8: After reset, every pointer and count reads 0xFF in both bytes. Every control, priority, interrupt and data-chain register reads 0x00. `irq` and `xfer_enable` are 0.
- R9: Interrupt bit 7 is set at the clock edge after any channel has both its enable bit and its control bit 7 set. Once set, it stays set until it is cleared by a read of 0x15.
- R10: `irq` equals interrupt bit 7 delayed by exactly one clock.
- R11: Reads of addresses 0x17 to 0x1F return 0xFF. Writes to those addresses change no register.
- R12: A pulse on `eng_start[n]` sets control bit 6 of channel n. A pulse on `eng_done[n]` sets bit 7 of channel n, clears its bit 6 and sets data-chain bit 4. While `eng_upd_en` is high, the pointer and count of channel `eng_upd_ch` are loaded from the engine. This load takes priority over a processor byte write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_en | input | 1 | Bus access strobe, one cycle per access |
| cpu_wr | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 5 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` (combinational) |
| eng_start | input | 4 | Per-channel start pulse from the engine |
| eng_done | input | 4 | Per-channel completion pulse from the engine |
| eng_upd_en | input | 1 | Load pointer and count of one channel |
| eng_upd_ch | input | 2 | Channel for the load |
| eng_upd_addr | input | 16 | New pointer value |
| eng_upd_count | input | 16 | New count value |
| xfer_enable | output | 1 | Global transfer enable (priority bit 0) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the interplay between the sticky interrupt bit and the two read-to-clear paths. Reading 0x15 while a channel's completion flag is still set must leave bit 7 set. The bit only drops after the control register has been read first. The bench drives a completion, reads 0x15 twice, then the control register, then 0x15 twice more, and checks each returned byte against the formula. A second scenario counts the exact clock on which `irq` rises and falls relative to the completion pulse and the clearing read.

// File: rtl/dmac_rf_pkg.sv
package dmac_rf_pkg;
    localparam int CH_COUNT = 4;
    localparam int BUS_AW   = 5;
    localparam int BUS_DW   = 8;
    localparam int CH_SEL_W = $clog2(CH_COUNT);

    localparam logic [BUS_AW-1:0] A_CTRL_BASE = 5'h10;
    localparam logic [BUS_AW-1:0] A_PRIO      = 5'h14;
    localparam logic [BUS_AW-1:0] A_INTR      = 5'h15;
    localparam logic [BUS_AW-1:0] A_CHAIN     = 5'h16;

    localparam logic [BUS_DW-1:0] PRIO_WMASK = 8'h8F;
    localparam logic [BUS_DW-1:0] UNUSED_RD  = 8'hFF;

    typedef enum logic [1:0] {
        SUB_PTR_HI = 2'd0,
        SUB_PTR_LO = 2'd1,
        SUB_CNT_HI = 2'd2,
        SUB_CNT_LO = 2'd3
    } sub_sel_t;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_rf_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_wr,
    input  logic [1:0]       sub,
    input  logic [7:0]       wdata,
    input  logic             ctrl_wr,
    input  logic             ctrl_rd,
    input  logic             eng_start,
    input  logic             eng_done,
    input  logic             upd_en,
    input  logic [PTR_W-1:0] upd_addr,
    input  logic [PTR_W-1:0] upd_count,
    output logic [PTR_W-1:0] addr_q,
    output logic [PTR_W-1:0] count_q,
    output logic [7:0]       ctrl_q
);
    localparam int HI_W = PTR_W - 8;

    sub_sel_t sub_e;
    assign sub_e = sub_sel_t'(sub);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '1;
            count_q <= '1;
        end else if (upd_en) begin
            addr_q  <= upd_addr;
            count_q <= upd_count;
        end else if (grp_wr) begin
            unique case (sub_e)
                SUB_PTR_HI: addr_q[PTR_W-1:8]  <= wdata[HI_W-1:0];
                SUB_PTR_LO: addr_q[7:0]        <= wdata;
                SUB_CNT_HI: count_q[PTR_W-1:8] <= wdata[HI_W-1:0];
                SUB_CNT_LO: count_q[7:0]       <= wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q[3:0] <= wdata[3:0];
            if (eng_done) begin
                ctrl_q[7] <= 1'b1;
                ctrl_q[6] <= 1'b0;
            end else begin
                if (eng_start) ctrl_q[6] <= 1'b1;
                if (ctrl_rd)   ctrl_q[7] <= 1'b0;
            end
        end
    end

    AST_CTRL_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_q[3:0])); // R2
    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (ctrl_q[7] && !ctrl_q[6])); // R12
    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !eng_done) |=> !ctrl_q[7]); // R3
endmodule

// File: rtl/dmac_shared_regs.sv
module dmac_shared_regs
    import dmac_rf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] wdata,
    input  logic       prio_wr,
    input  logic       intr_wr,
    input  logic       intr_rd,
    input  logic       chain_wr,
    input  logic       done_any,
    input  logic       irq_cond,
    output logic [7:0] prio_q,
    output logic [7:0] intr_q,
    output logic [7:0] chain_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (prio_wr) begin
            prio_q <= wdata & PRIO_WMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_q <= '0;
        end else begin
            if (intr_wr) intr_q[3:0] <= wdata[3:0];
            intr_q[7] <= irq_cond | (intr_q[7] & ~intr_rd);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            if (chain_wr) chain_q[3:0] <= wdata[3:0];
            if (intr_rd)  chain_q[7:4] <= 4'h0;
            if (done_any) chain_q[4]   <= 1'b1;
        end
    end

    AST_PRIO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        prio_wr |=> (prio_q == ($past(wdata) & 8'h8F))); // R4
    AST_SUMMARY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cond |=> intr_q[7]); // R9
    AST_SUMMARY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_q[7] && !intr_rd) |=> intr_q[7]); // R9
endmodule

// File: rtl/dmac_irq_fsm.sv
module dmac_irq_fsm
    import dmac_rf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic summary,
    output logic irq
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (summary)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!summary) state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        summary |=> irq); // R10
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !summary |=> !irq); // R10
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_rf_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_en,
    input  logic                cpu_wr,
    input  logic [BUS_AW-1:0]   cpu_addr,
    input  logic [BUS_DW-1:0]   cpu_wdata,
    output logic [BUS_DW-1:0]   cpu_rdata,
    input  logic [CH_COUNT-1:0] eng_start,
    input  logic [CH_COUNT-1:0] eng_done,
    input  logic                eng_upd_en,
    input  logic [CH_SEL_W-1:0] eng_upd_ch,
    input  logic [PTR_W-1:0]    eng_upd_addr,
    input  logic [PTR_W-1:0]    eng_upd_count,
    output logic                xfer_enable,
    output logic                irq
);
    logic wr_stb, rd_stb;
    assign wr_stb = cpu_en & cpu_wr;
    assign rd_stb = cpu_en & ~cpu_wr;

    logic [CH_COUNT-1:0][PTR_W-1:0] addr_q;
    logic [CH_COUNT-1:0][PTR_W-1:0] count_q;
    logic [CH_COUNT-1:0][7:0]       ctrl_q;
    logic [CH_COUNT-1:0]            done_flags;

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_chan
        logic grp_wr, ctrl_wr, ctrl_rd, upd_en;
        assign grp_wr  = wr_stb && !cpu_addr[4] && (cpu_addr[3:2] == CH_SEL_W'(g));
        assign ctrl_wr = wr_stb && (cpu_addr == A_CTRL_BASE + BUS_AW'(g));
        assign ctrl_rd = rd_stb && (cpu_addr == A_CTRL_BASE + BUS_AW'(g));
        assign upd_en  = eng_upd_en && (eng_upd_ch == CH_SEL_W'(g));

        dmac_chan_regs #(.PTR_W(PTR_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .grp_wr    (grp_wr),
            .sub       (cpu_addr[1:0]),
            .wdata     (cpu_wdata),
            .ctrl_wr   (ctrl_wr),
            .ctrl_rd   (ctrl_rd),
            .eng_start (eng_start[g]),
            .eng_done  (eng_done[g]),
            .upd_en    (upd_en),
            .upd_addr  (eng_upd_addr),
            .upd_count (eng_upd_count),
            .addr_q    (addr_q[g]),
            .count_q   (count_q[g]),
            .ctrl_q    (ctrl_q[g])
        );
        assign done_flags[g] = ctrl_q[g][7];
    end

    logic [7:0] prio_q, intr_q, chain_q;
    logic       irq_cond;
    assign irq_cond = |(intr_q[CH_COUNT-1:0] & done_flags);

    dmac_shared_regs u_shared (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (cpu_wdata),
        .prio_wr  (wr_stb && (cpu_addr == A_PRIO)),
        .intr_wr  (wr_stb && (cpu_addr == A_INTR)),
        .intr_rd  (rd_stb && (cpu_addr == A_INTR)),
        .chain_wr (wr_stb && (cpu_addr == A_CHAIN)),
        .done_any (|eng_done),
        .irq_cond (irq_cond),
        .prio_q   (prio_q),
        .intr_q   (intr_q),
        .chain_q  (chain_q)
    );

    dmac_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .summary (intr_q[7]),
        .irq     (irq)
    );

    assign xfer_enable = prio_q[0];

    always_comb begin
        cpu_rdata = UNUSED_RD;
        if (!cpu_addr[4]) begin
            unique case (sub_sel_t'(cpu_addr[1:0]))
                SUB_PTR_HI: cpu_rdata = 8'(addr_q[cpu_addr[3:2]][PTR_W-1:8]);
                SUB_PTR_LO: cpu_rdata = addr_q[cpu_addr[3:2]][7:0];
                SUB_CNT_HI: cpu_rdata = 8'(count_q[cpu_addr[3:2]][PTR_W-1:8]);
                SUB_CNT_LO: cpu_rdata = count_q[cpu_addr[3:2]][7:0];
            endcase
        end else if (cpu_addr[3:2] == 2'b00) begin
            cpu_rdata = ctrl_q[cpu_addr[1:0]];
        end else if (cpu_addr == A_PRIO) begin
            cpu_rdata = prio_q;
        end else if (cpu_addr == A_INTR) begin
            cpu_rdata = ((chain_q >> 4) | 8'h80) & intr_q;
        end else if (cpu_addr == A_CHAIN) begin
            cpu_rdata = {4'h0, chain_q[3:0]};
        end
    end

    AST_ENABLE_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cpu_addr == A_PRIO) |=> (xfer_enable == $past(cpu_wdata[0]))); // R4
endmodule

// File: tb/tb_dmac_regfile.sv
`timescale 1ns/1ps
module tb_dmac_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_en = 1'b0, cpu_wr = 1'b0;
    logic [4:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [3:0]  eng_start = '0, eng_done = '0;
    logic        eng_upd_en = 1'b0;
    logic [1:0]  eng_upd_ch = '0;
    logic [15:0] eng_upd_addr = '0, eng_upd_count = '0;
    logic        xfer_enable, irq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dmac_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_en(cpu_en), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .eng_start(eng_start), .eng_done(eng_done),
        .eng_upd_en(eng_upd_en), .eng_upd_ch(eng_upd_ch),
        .eng_upd_addr(eng_upd_addr), .eng_upd_count(eng_upd_count),
        .xfer_enable(xfer_enable), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
        cpu_en = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        tick();
        cpu_en = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
        cpu_en = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        tick();
        cpu_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse_done(input logic [3:0] m);
        eng_done = m; tick(); eng_done = '0;
    endtask

    task automatic t_reset();
        do_reset();
        rd_check("R8 ptr hi", 5'h00, 8'hFF);
        rd_check("R8 cnt lo", 5'h0F, 8'hFF);
        rd_check("R8 ctrl", 5'h12, 8'h00);
        rd_check("R8 prio", 5'h14, 8'h00);
        check("R8 irq", {7'd0, irq}, 8'h00);
        check("R8 xfer_enable", {7'd0, xfer_enable}, 8'h00);
    endtask

    task automatic t_map();
        do_reset();
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++)
                bus_wr(5'(c*4+s), 8'(8'h10*c + s + 1));
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++)
                rd_check("R1 group byte", 5'(c*4+s), 8'(8'h10*c + s + 1));
    endtask

    task automatic t_ctrl();
        do_reset();
        bus_wr(5'h11, 8'hFF);
        rd_check("R2 write mask", 5'h11, 8'h0F);
        pulse_done(4'b0010);
        bus_wr(5'h11, 8'h03);
        rd_check("R2 R3 flag kept on write, full read", 5'h11, 8'h83);
        rd_check("R3 flag cleared by read", 5'h11, 8'h03);
    endtask

    task automatic t_prio();
        do_reset();
        bus_wr(5'h14, 8'hFF);
        rd_check("R4 mask", 5'h14, 8'h8F);
        check("R4 enable high", {7'd0, xfer_enable}, 8'h01);
        bus_wr(5'h14, 8'h70);
        check("R4 enable low", {7'd0, xfer_enable}, 8'h00);
        rd_check("R4 mask zero", 5'h14, 8'h00);
    endtask

    task automatic t_chain_reg();
        do_reset();
        bus_wr(5'h16, 8'hFF);
        rd_check("R7 low nibble only", 5'h16, 8'h0F);
        bus_wr(5'h15, 8'hF1);
        rd_check("R5 enables only, bit7 stays 0", 5'h15, 8'h00);
    endtask

    task automatic t_sticky();
        do_reset();
        bus_wr(5'h15, 8'h01);
        pulse_done(4'b0001);
        tick();
        rd_check("R6 merged read", 5'h15, 8'h81);
        rd_check("R6 R9 chain cleared, summary held", 5'h15, 8'h80);
        rd_check("R3 ctrl read", 5'h10, 8'h80);
        rd_check("R9 still set after flag clear", 5'h15, 8'h80);
        rd_check("R6 summary cleared", 5'h15, 8'h00);
    endtask

    task automatic t_irq_timing();
        do_reset();
        bus_wr(5'h15, 8'h04);
        pulse_done(4'b0100);
        check("R10 irq low at flag edge", {7'd0, irq}, 8'h00);
        tick();
        check("R10 irq low at summary edge", {7'd0, irq}, 8'h00);
        tick();
        check("R10 irq high one clock later", {7'd0, irq}, 8'h01);
        rd_check("R3 ctrl2 read", 5'h12, 8'h80);
        rd_check("R6 read with chain bit", 5'h15, 8'h80);
        check("R10 irq still high after clearing read", {7'd0, irq}, 8'h01);
        tick();
        check("R10 irq falls", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_unused();
        do_reset();
        bus_wr(5'h14, 8'h01);
        bus_wr(5'h16, 8'h05);
        for (int a = 5'h17; a <= 5'h1F; a++) bus_wr(5'(a), 8'h00);
        for (int a = 5'h17; a <= 5'h1F; a++) rd_check("R11 unused reads FF", 5'(a), 8'hFF);
        rd_check("R11 prio untouched", 5'h14, 8'h01);
        rd_check("R11 chain untouched", 5'h16, 8'h05);
        rd_check("R11 ctrl untouched", 5'h13, 8'h00);
    endtask

    task automatic t_engine();
        do_reset();
        eng_start = 4'b0010; tick(); eng_start = '0;
        rd_check("R12 busy set", 5'h11, 8'h40);
        pulse_done(4'b0010);
        rd_check("R12 done sets 7 clears 6", 5'h11, 8'h80);
        bus_wr(5'h15, 8'h01);
        rd_check("R12 chain bit4 via merged read", 5'h15, 8'h01);
        eng_upd_en = 1'b1; eng_upd_ch = 2'd3;
        eng_upd_addr = 16'h1234; eng_upd_count = 16'h0056;
        cpu_en = 1'b1; cpu_wr = 1'b1; cpu_addr = 5'h0D; cpu_wdata = 8'hEE;
        tick();
        cpu_en = 1'b0; cpu_wr = 1'b0; eng_upd_en = 1'b0;
        rd_check("R12 load ptr hi", 5'h0C, 8'h12);
        rd_check("R12 load wins over write", 5'h0D, 8'h34);
        rd_check("R12 load cnt hi", 5'h0E, 8'h00);
        rd_check("R12 load cnt lo", 5'h0F, 8'h56);
        rd_check("R12 other channel intact", 5'h08, 8'hFF);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_map();
        t_ctrl();
        t_prio();
        t_chain_reg();
        t_sticky();
        t_irq_timing();
        t_unused();
        t_engine();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule